// File: doc/BRIEF.md
# Seconds Countdown Alarm Timer

This block is a relative alarm. Software writes a number of seconds into it over a simple memory-mapped register port. While counting is switched on, every one-second tick lowers the remaining count by one. When the count goes from one to zero, a sticky pending flag is set. That flag can drive an interrupt line and a system wakeup line, and each of the two has its own enable.

The register port is a single-cycle write strobe with an address and write data. Read data is a combinational function of the address. Six word registers are mapped:

| Offset | Contents |
|---|---|
| 0x00 | Load value |
| 0x04 | Remaining count (read-only) |
| 0x08 | Run enable, bit 0 |
| 0x0C | Interrupt enable, bit 0 |
| 0x10 | Pending status, bit 0, write-1-to-clear |
| 0x14 | Wakeup enable, bit 0 |

Writing the load value copies it straight into the remaining count. Writing zero therefore cancels a countdown that is in progress.

Top module: `sca_alarm_timer`

## Requirements
- R1: After reset the load value, remaining count, run enable, interrupt enable, wakeup enable and pending flag all read 0, and `irq_o` and `wake_o` are 0.
- R2: A write to offset 0x00 stores the data as the load value (read back at 0x00) and sets the remaining count (read at 0x04) to the same value from the next cycle on.
- R3: On a cycle with `tick_i` high, run enable (0x08 bit 0) set, a nonzero count and no load write, the count drops by exactly one. If run enable is clear or `tick_i` is low, the count holds.
- R4: A count of zero stays zero on later ticks. It never wraps.
- R5: The tick that takes the count from 1 to 0 sets the pending flag (0x10 bit 0). Ticks that arrive while the count is already zero do not set it again.
- R6: Writing 0x10 with bit 0 set clears the pending flag. Writing 0x10 with bit 0 clear leaves it unchanged. Otherwise the flag stays set.
- R7: If a clearing write to 0x10 lands in the same cycle as an expiring tick, the pending flag is 1 afterwards.
- R8: `irq_o` is 1 exactly when the pending flag and interrupt enable (0x0C bit 0) are both 1.
- R9: `wake_o` is 1 exactly when the pending flag and wakeup enable (0x14 bit 0) are both 1.
- R10: Writing 0 to 0x00 during a countdown makes the count 0 without setting the pending flag.
- R11: A load write in the same cycle as a tick takes precedence. The count becomes the written value and is not decremented.
- R12: The enable registers keep only bit 0, and read 0 in bits 31..1. Any offset not listed above reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | System wakeup request |

## Verification
The hardest case to reach is a write-1 clear arriving in the very cycle an expiring tick comes in. The pending flag must already be set when this happens, otherwise the priority of the set over the clear cannot be seen. The stimulus first lets one countdown expire and leaves its flag pending. It then reloads a count of one and, in a single cycle, drives the status write together with `tick_i`. After that it reads the flag and the count, and only then clears the flag normally.

// File: rtl/sca_pkg.sv
// Package: sca_pkg
// Shared register offsets and the decoded register selector of the seconds
// countdown alarm. Assumes byte offsets of word registers.
package sca_pkg;

    localparam int OFF_LOAD   = 'h00;
    localparam int OFF_REMAIN = 'h04;
    localparam int OFF_RUN    = 'h08;
    localparam int OFF_IRQEN  = 'h0C;
    localparam int OFF_STATUS = 'h10;
    localparam int OFF_WAKEEN = 'h14;

    // Index of each one-bit control inside the control vector.
    localparam int CTL_RUN   = 0;
    localparam int CTL_IRQEN = 1;
    localparam int CTL_WAKE  = 2;
    localparam int CTL_N     = 3;

    typedef enum logic [2:0] {
        SEL_LOAD,
        SEL_REMAIN,
        SEL_RUN,
        SEL_IRQEN,
        SEL_STATUS,
        SEL_WAKEEN,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/sca_regs.sv
// Module: sca_regs
// Register port of the alarm: decodes the offset, holds the load value and
// the three one-bit enables, issues load and clear strobes and builds the
// read data. Assumes single-cycle writes and combinational reads.
module sca_regs
    import sca_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              pending_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              load_wr_o,
    output logic [DATA_W-1:0] load_val_o,
    output logic              clr_o,
    output logic [CTL_N-1:0]  ctl_o
);

    reg_sel_e          sel;
    logic [CTL_N-1:0]  ctl_hit;
    logic [DATA_W-1:0] load_q;
    logic [CTL_N-1:0]  ctl_q;

    // Map the byte offset to a register selector.
    always_comb begin
        if (addr_i == ADDR_W'(OFF_LOAD))        sel = SEL_LOAD;
        else if (addr_i == ADDR_W'(OFF_REMAIN)) sel = SEL_REMAIN;
        else if (addr_i == ADDR_W'(OFF_RUN))    sel = SEL_RUN;
        else if (addr_i == ADDR_W'(OFF_IRQEN))  sel = SEL_IRQEN;
        else if (addr_i == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
        else if (addr_i == ADDR_W'(OFF_WAKEEN)) sel = SEL_WAKEEN;
        else                                    sel = SEL_NONE;
    end

    // Write strobes for the one-bit control registers.
    always_comb begin
        ctl_hit            = '0;
        ctl_hit[CTL_RUN]   = wr_i && (sel == SEL_RUN);
        ctl_hit[CTL_IRQEN] = wr_i && (sel == SEL_IRQEN);
        ctl_hit[CTL_WAKE]  = wr_i && (sel == SEL_WAKEEN);
    end

    assign load_wr_o  = wr_i && (sel == SEL_LOAD);
    assign clr_o      = wr_i && (sel == SEL_STATUS) && wdata_i[0];
    assign load_val_o = wdata_i;
    assign ctl_o      = ctl_q;

    // Hold the last written load value.
    always_ff @(posedge clk) begin
        if (!rst_n)         load_q <= '0;
        else if (load_wr_o) load_q <= wdata_i;
    end

    // One flop per control enable, each keeping only bit 0 of the write.
    for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n)          ctl_q[g] <= 1'b0;
            else if (ctl_hit[g]) ctl_q[g] <= wdata_i[0];
        end
    end

    // Read data multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_LOAD:   rdata_o = load_q;
            SEL_REMAIN: rdata_o = count_i;
            SEL_RUN:    rdata_o[0] = ctl_q[CTL_RUN];
            SEL_IRQEN:  rdata_o[0] = ctl_q[CTL_IRQEN];
            SEL_STATUS: rdata_o[0] = pending_i;
            SEL_WAKEEN: rdata_o[0] = ctl_q[CTL_WAKE];
            default:    rdata_o = '0;
        endcase
    end

    // R12: a write to an enable register leaves exactly bit 0 of the data
    a_r12_ctl_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_hit[CTL_RUN]))
            |-> (ctl_q[CTL_RUN] == $past(wdata_i[0])));

endmodule

// File: rtl/sca_counter.sv
// Module: sca_counter
// Remaining-seconds counter. A load overrides everything. Otherwise a tick
// with run enabled lowers a nonzero count by one. Emits a one-cycle expire
// strobe on the 1->0 step. Assumes tick_i is a one-cycle pulse.
module sca_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              load_wr_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] count_o,
    output logic              expire_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q;
    logic              nonzero;
    logic              step;

    assign nonzero  = |cnt_q;
    assign step     = tick_i && run_i && nonzero && !load_wr_i;
    assign expire_o = step && (cnt_q == ONE);
    assign count_o  = cnt_q;

    // Load, decrement or hold the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (load_wr_i) cnt_q <= load_val_i;
        else if (step)      cnt_q <= cnt_q - ONE;
    end

    // R2, R11: a load write lands unchanged, even with a tick present
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_wr_i)) |-> (cnt_q == $past(load_val_i)));

    // R3: an enabled tick on a nonzero count lowers it by exactly one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_i && run_i && (cnt_q != '0) && !load_wr_i))
            |-> (cnt_q == $past(cnt_q) - ONE));

    // R4: zero stays zero unless reloaded
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_q == '0) && !$past(load_wr_i))
            |-> (cnt_q == '0));

endmodule

// File: rtl/sca_pending.sv
// Module: sca_pending
// Sticky alarm pending flag with write-1-to-clear, where a same-cycle expiry
// wins over the clear, and the gated interrupt and wakeup outputs.
module sca_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic irq_en_i,
    input  logic wake_en_i,
    output logic pending_o,
    output logic irq_o,
    output logic wake_o
);

    logic pend_q;

    // Set on expiry, clear on write-1, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (expire_i) pend_q <= 1'b1;
        else if (clr_i)    pend_q <= 1'b0;
    end

    assign pending_o = pend_q;
    assign irq_o     = pend_q && irq_en_i;
    assign wake_o    = pend_q && wake_en_i;

    // R5, R7: an expiry always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(expire_i)) |-> pend_q);

    // R6: without a clear the flag is sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pend_q) && !$past(clr_i)) |-> pend_q);

    // R6: a clear with no expiry drops the flag
    a_r6_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_i) && !$past(expire_i)) |-> !pend_q);

endmodule

// File: rtl/sca_alarm_timer.sv
// Module: sca_alarm_timer
// Top of the seconds countdown alarm: register port, counter and pending
// logic. Assumes tick_i is a one-cycle pulse synchronous to clk.
module sca_alarm_timer
    import sca_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);

    logic              load_wr;
    logic [DATA_W-1:0] load_val;
    logic              clr;
    logic [CTL_N-1:0]  ctl;
    logic [DATA_W-1:0] count;
    logic              expire;
    logic              pending;

    sca_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .count_i    (count),
        .pending_i  (pending),
        .rdata_o    (bus_rdata_o),
        .load_wr_o  (load_wr),
        .load_val_o (load_val),
        .clr_o      (clr),
        .ctl_o      (ctl)
    );

    sca_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (ctl[CTL_RUN]),
        .load_wr_i  (load_wr),
        .load_val_i (load_val),
        .count_o    (count),
        .expire_o   (expire)
    );

    sca_pending u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .clr_i      (clr),
        .irq_en_i   (ctl[CTL_IRQEN]),
        .wake_en_i  (ctl[CTL_WAKE]),
        .pending_o  (pending),
        .irq_o      (irq_o),
        .wake_o     (wake_o)
    );

    // R5: the flag only rises when the count has reached zero
    a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (count == '0));

    // R8: no interrupt without a pending alarm
    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pending);

    // R9: no wakeup without a pending alarm
    a_r9_wake_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> pending);

endmodule

// File: tb/sim_sca_alarm_timer.sv
module sim_sca_alarm_timer;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [7:0] A_LOAD = 8'h00, A_REM = 8'h04, A_RUN = 8'h08,
                           A_IRQ = 8'h0C, A_STAT = 8'h10, A_WAKE = 8'h14,
                           A_BAD = 8'h3C;

    typedef struct {
        int          kind;   // 0 read data, 1 irq pin, 2 wake pin
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              bus_wr_i = 1'b0;
    logic [ADDR_W-1:0] bus_addr_i = '0;
    logic [DATA_W-1:0] bus_wdata_i = '0;
    logic [DATA_W-1:0] bus_rdata_o;
    logic              irq_o;
    logic              wake_o;

    sb_item_t sb_q[$];
    int total = 0;
    int bad   = 0;
    bit finished = 0;

    sca_alarm_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Monitor: pops one expected item per falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = (it.kind == 0) ? bus_rdata_o :
                      (it.kind == 1) ? {31'd0, irq_o} : {31'd0, wake_o};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver side of the scoreboard: queue an expectation and wait for it.
    task automatic expect_item(input int kind, input logic [7:0] addr,
                               input logic [31:0] exp, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr_i = addr;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        expect_item(0, a, e, t);
    endtask

    // One bus write, optionally with a tick in the same cycle.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk);
        @(posedge clk); #1;
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
        @(posedge clk); #1;
        bus_wr_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        tick_i = 1'b1;
        @(posedge clk); #1;
        tick_i = 1'b0;
    endtask

    // Watchdog.
    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_LOAD, 0, "R1 load");
        rd(A_REM, 0, "R1 remaining");
        rd(A_STAT, 0, "R1 pending");
        rd(A_RUN, 0, "R1 run");
        expect_item(1, A_LOAD, 0, "R1 irq");
        expect_item(2, A_LOAD, 0, "R1 wake");

        // R2 load, R12 unmapped
        wr(A_LOAD, 32'd3, 0);
        rd(A_LOAD, 3, "R2 load readback");
        rd(A_REM, 3, "R2 remaining");
        rd(A_BAD, 0, "R12 unmapped");

        // R3 no enable: hold
        tick();
        rd(A_REM, 3, "R3 hold when stopped");
        // R12 upper bits dropped: run stays off
        wr(A_RUN, 32'hFFFF_FFFE, 0);
        rd(A_RUN, 0, "R12 run bit0 only");
        tick();
        rd(A_REM, 3, "R3 hold with run 0");

        wr(A_RUN, 32'hFFFF_FFFF, 0);
        rd(A_RUN, 1, "R12 run readback");
        tick();
        rd(A_REM, 2, "R3 decrement");
        repeat (4) @(posedge clk);
        rd(A_REM, 2, "R3 hold without tick");

        // R5 expiry, R8/R9 gating
        wr(A_IRQ, 1, 0);
        tick();
        rd(A_STAT, 0, "R5 not yet pending");
        tick();
        rd(A_REM, 0, "R5 reached zero");
        rd(A_STAT, 1, "R5 pending set");
        expect_item(1, A_LOAD, 1, "R8 irq on");
        expect_item(2, A_LOAD, 0, "R9 wake off");

        // R4 no wrap
        tick();
        rd(A_REM, 0, "R4 stays zero");

        // R6 write 0 no effect, R9 wake
        wr(A_STAT, 0, 0);
        rd(A_STAT, 1, "R6 write0 ignored");
        wr(A_WAKE, 1, 0);
        expect_item(2, A_LOAD, 1, "R9 wake on");
        wr(A_IRQ, 0, 0);
        expect_item(1, A_LOAD, 0, "R8 irq masked");
        wr(A_IRQ, 1, 0);
        wr(A_STAT, 1, 0);
        rd(A_STAT, 0, "R6 cleared");
        expect_item(1, A_LOAD, 0, "R8 irq off after clear");
        expect_item(2, A_LOAD, 0, "R9 wake off after clear");

        // R5 only once
        tick();
        rd(A_STAT, 0, "R5 no re-fire at zero");

        // R7 simultaneous clear and expiry
        wr(A_LOAD, 1, 0);
        tick();
        rd(A_STAT, 1, "R7 first expiry");
        wr(A_LOAD, 1, 0);
        @(posedge clk); #1;
        bus_wr_i = 1'b1; bus_addr_i = A_STAT; bus_wdata_i = 1; tick_i = 1'b1;
        @(posedge clk); #1;
        bus_wr_i = 1'b0; tick_i = 1'b0;
        rd(A_STAT, 1, "R7 set wins");
        rd(A_REM, 0, "R7 count zero");
        wr(A_STAT, 1, 0);
        rd(A_STAT, 0, "R7 later clear");

        // R10 cancel by writing zero
        wr(A_LOAD, 4, 0);
        tick();
        rd(A_REM, 3, "R10 counting");
        wr(A_LOAD, 0, 0);
        rd(A_REM, 0, "R10 cancelled");
        tick();
        rd(A_STAT, 0, "R10 no pending");

        // R11 load beats tick
        wr(A_LOAD, 7, 1);
        rd(A_REM, 7, "R11 load wins");
        tick();
        rd(A_REM, 6, "R11 then counts");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule